// File: doc/BRIEF.md
# Cascadable Parallel-In Serial-Out Register

This block holds a word of `WIDTH` stages (eight by default) and presents only its most significant stage on a single serial output. On a rising clock edge with the clock enable active, the block does one of two things. It either captures a full parallel word, or it shifts every stage one place toward the output and takes a new bit from the serial input into stage 0. With the enable inactive, edges leave the word unchanged. Several blocks can be chained into a longer converter by wiring the serial output of one to the serial input of the next.

An active-low reset clears every stage at once, without waiting for a clock edge, and overrides all other inputs. Release of the reset passes through a small sequencer. Its states are `RS_ASSERT` (reset held, or just released and not yet sampled), `RS_SETTLE` (counting extra settling edges, used only when `SYNC_STAGES` is above 2) and `RS_RUN` (register live). Its transitions are:

- `RS_ASSERT`→`RS_RUN` once the release has been sampled, when `SYNC_STAGES` is 2.
- `RS_ASSERT`→`RS_SETTLE` once the release has been sampled, when `SYNC_STAGES` is above 2.
- `RS_SETTLE`→`RS_RUN` after the last settling edge.
- Any state→`RS_ASSERT` asynchronously on reset.

The operation selected on each edge is one of `OP_HOLD` (enable inactive), `OP_LOAD` (enable active, load select low) and `OP_SHIFT` (enable active, load select high).

Top module: `piso_chain_reg`

## Requirements
- R1: While `rst_n` is low, `ser_out` is 0 and all stages are 0; a falling `rst_n` clears them immediately, with no clock edge.
- R2: After `rst_n` rises, the first `SYNC_STAGES` (default 2) rising clock edges leave all stages at 0 whatever the other inputs are; the next edge acts normally.
- R3: A rising edge with `ce_n`=0 and `load_n`=0 copies `par_in[i]` into stage i for every i, so `ser_out` then equals `par_in[WIDTH-1]`.
- R4: A rising edge with `ce_n`=0 and `load_n`=1 puts `ser_in` into stage 0 and the old stage i-1 into stage i for i from 1 to WIDTH-1, so `ser_out` then shows the old stage WIDTH-2.
- R5: A rising edge with `ce_n`=1 changes no stage, whatever `load_n`, `ser_in` and `par_in` are.
- R6: Changes of `par_in` or `ser_in` between rising edges do not change `ser_out`; only the values present at an edge count.
- R7: After a load of word W, successive shift edges present W[WIDTH-1], W[WIDTH-2], … W[0] on `ser_out`. After that, the serial-input bits appear in the order they were shifted in, WIDTH edges late, which lets the block be cascaded.
- R8: A reset applied in the middle of a shift sequence forces `ser_out` to 0 at once, even with `ce_n`=0 and `load_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear of all stages |
| ce_n | input | 1 | Active-low clock enable |
| load_n | input | 1 | Low selects parallel load, high selects shift |
| ser_in | input | 1 | Serial bit taken into stage 0 on a shift |
| par_in | input | WIDTH | Parallel word, bit i goes to stage i |
| ser_out | output | 1 | Most significant stage |

## Verification
Only the last stage is visible, so a wrong bit in stage i reaches `ser_out` only after WIDTH-1-i further shift edges, or never if a load overwrites it first. The bench therefore follows every load with at least WIDTH shifts, and compares the output on every cycle against a reference model. A wrong hold, or an early reset release, appears within one edge whenever the word held has a 0 and a 1 in the top stages. A shift-order fault appears within WIDTH edges.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        RS_ASSERT = 2'd0,
        RS_SETTLE = 2'd1,
        RS_RUN    = 2'd2
    } rs_state_e;

endpackage

// File: rtl/piso_rst_release.sv
module piso_rst_release
    import piso_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rel_n
);

    localparam int CW          = $clog2(SYNC_STAGES + 1);
    localparam int SETTLE_LAST = (SYNC_STAGES > 2) ? SYNC_STAGES - 3 : 0;

    rs_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            meta_q;
    logic            rel_q;

    // State register: asynchronous entry into RS_ASSERT, synchronous exit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= 1'b0;
            state_q <= RS_ASSERT;
            cnt_q   <= '0;
            rel_q   <= 1'b0;
        end else begin
            meta_q  <= 1'b1;
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rel_q   <= (state_d == RS_RUN);
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_ASSERT: begin
                if (meta_q) begin
                    cnt_d = '0;
                    if (SYNC_STAGES <= 2) state_d = RS_RUN;
                    else                  state_d = RS_SETTLE;
                end
            end
            RS_SETTLE: begin
                if (cnt_q == CW'(SETTLE_LAST)) state_d = RS_RUN;
                else                           cnt_d   = cnt_q + 1'b1;
            end
            RS_RUN: begin
                state_d = RS_RUN;
            end
            default: begin
                state_d = RS_ASSERT;
            end
        endcase
    end

    assign rel_n = rel_q;

    // R2: release only after the sampled reset release has been seen
    p_rel_after_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_q) |-> $past(meta_q));

    // R2: once live, stays live until the next reset
    p_rel_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q |=> rel_q);

endmodule

// File: rtl/piso_op_decode.sv
module piso_op_decode
    import piso_pkg::*;
(
    input  logic ce_n,
    input  logic load_n,
    output op_e  op
);

    always_comb begin
        if (ce_n)        op = OP_HOLD;
        else if (!load_n) op = OP_LOAD;
        else             op = OP_SHIFT;
    end

endmodule

// File: rtl/piso_stage_bank.sv
module piso_stage_bank
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rel_n,
    input  op_e              op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             last_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] shift_src;
    logic [WIDTH-1:0] q_d;

    // Source of each stage when shifting: stage 0 from the serial input,
    // every other stage from its lower neighbour.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign shift_src[i] = ser_in;
        end else begin : g_body
            assign shift_src[i] = q[i-1];
        end
    end

    always_comb begin
        unique case (op)
            OP_LOAD:  q_d = par_in;
            OP_SHIFT: q_d = shift_src;
            OP_HOLD:  q_d = q;
            default:  q_d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rel_n) begin
        if (!rel_n) q <= '0;
        else        q <= q_d;
    end

    assign last_o = q[MSB];

    // R3: parallel capture
    p_load_r3: assert property (@(posedge clk) disable iff (!rel_n)
        (rel_n && op == OP_LOAD) |=> q == $past(par_in));

    // R4: serial bit enters stage 0
    p_shift_head_r4: assert property (@(posedge clk) disable iff (!rel_n)
        (rel_n && op == OP_SHIFT) |=> q[0] == $past(ser_in));

    // R4: every other stage takes its neighbour
    p_shift_body_r4: assert property (@(posedge clk) disable iff (!rel_n)
        (rel_n && op == OP_SHIFT) |=> q[MSB:1] == $past(q[MSB-1:0]));

    // R5: disabled edges keep all stages
    p_hold_r5: assert property (@(posedge clk) disable iff (!rel_n)
        (rel_n && op == OP_HOLD) |=> $stable(q));

endmodule

// File: rtl/piso_chain_reg.sv
module piso_chain_reg
    import piso_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             load_n,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);

    logic rel_n;
    op_e  op;

    piso_rst_release #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .rel_n (rel_n)
    );

    piso_op_decode u_dec (
        .ce_n   (ce_n),
        .load_n (load_n),
        .op     (op)
    );

    piso_stage_bank #(
        .WIDTH (WIDTH)
    ) u_bank (
        .clk    (clk),
        .rel_n  (rel_n),
        .op     (op),
        .ser_in (ser_in),
        .par_in (par_in),
        .last_o (ser_out)
    );

    // R1: output is zero whenever reset is held
    p_out_zero_r1: assert property (@(posedge clk) disable iff (rst_n)
        ser_out == 1'b0);

    // R2: no stage leaves zero on the edge that samples the release
    p_first_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> ser_out == 1'b0);

endmodule

// File: tb/piso_chain_reg_tb.sv
module piso_chain_reg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int SYNC       = 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ce_n;
    logic         load_n;
    logic         ser_in;
    logic [W-1:0] par_in;
    logic         ser_out;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R1";
    bit    done     = 1'b0;

    logic [W-1:0] mdl;
    int           blk;

    piso_chain_reg #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .load_n  (load_n),
        .ser_in  (ser_in),
        .par_in  (par_in),
        .ser_out (ser_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, got, exp);
        end
    endtask

    // Behavioural reference model.
    always @(posedge clk) begin
        if (!rst_n) begin
            mdl = '0;
            blk = 0;
        end else if (blk < SYNC) begin
            blk++;
        end else if (!ce_n) begin
            if (load_n) mdl = {mdl[W-2:0], ser_in};
            else        mdl = par_in;
        end
    end

    always @(negedge rst_n) begin
        mdl = '0;
        blk = 0;
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!done) chk(ser_out, mdl[W-1], cur_tag);
    end

    task automatic drive(input logic ce, input logic ld, input logic si,
                         input logic [W-1:0] pw, input string tag);
        @(negedge clk);
        #1;
        ce_n    = ce;
        load_n  = ld;
        ser_in  = si;
        par_in  = pw;
        cur_tag = tag;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] word;
        logic [W-1:0] sbits;
        rst_n  = 1'b0;
        ce_n   = 1'b0;
        load_n = 1'b0;
        ser_in = 1'b1;
        par_in = '1;
        mdl    = '0;
        blk    = 0;

        // R1: reset state with load requested
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 1'b1, '1, "R1");
        chk(ser_out, 1'b0, "R1");

        // R2: release; first SYNC edges stay cleared
        @(negedge clk);
        #1;
        rst_n   = 1'b1;
        cur_tag = "R2";
        @(posedge clk);
        #2 chk(ser_out, 1'b0, "R2");
        @(posedge clk);
        #2 chk(ser_out, 1'b0, "R2");
        @(posedge clk);
        #2 chk(ser_out, 1'b1, "R2");

        // R3: load a word, R7: shift it out MSB first
        word  = 8'hA5;
        sbits = 8'b1011_0010;
        drive(1'b0, 1'b0, 1'b0, word, "R3");
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            #1;
            chk(ser_out, word[W-1-k], "R7");
            ce_n    = 1'b0;
            load_n  = 1'b1;
            ser_in  = sbits[k];
            par_in  = 8'h3C;
            cur_tag = "R4";
        end
        // R7: serial bits emerge W edges later, in order
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            #1;
            chk(ser_out, sbits[k], "R7");
            ce_n    = 1'b0;
            load_n  = 1'b1;
            ser_in  = ~sbits[k];
            cur_tag = "R4";
        end

        // R5: disabled edges hold, load and shift selects ignored
        drive(1'b0, 1'b0, 1'b0, 8'h40, "R3");
        for (int i = 0; i < 4; i++)
            drive(1'b1, i[0], ~i[0], 8'h80 ^ 8'(i), "R5");
        chk(ser_out, 1'b0, "R5");

        // R6: mid-cycle input changes have no effect until the edge
        drive(1'b0, 1'b0, 1'b0, 8'h00, "R6");
        #1 chk(ser_out, 1'b0, "R6");
        par_in = 8'h80;
        ser_in = 1'b1;
        #1 chk(ser_out, 1'b0, "R6");
        @(posedge clk);
        #2 chk(ser_out, 1'b1, "R6");

        // R4: mixed random traffic against the model
        for (int i = 0; i < 40; i++)
            drive(1'b0, ($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                  W'($urandom), "R4");

        // R8: reset in the middle of a shift sequence
        drive(1'b0, 1'b0, 1'b0, 8'hFF, "R3");
        drive(1'b0, 1'b1, 1'b1, 8'hFF, "R4");
        drive(1'b0, 1'b1, 1'b1, 8'hFF, "R4");
        @(negedge clk);
        #2;
        chk(ser_out, 1'b1, "R8");
        ce_n    = 1'b0;
        load_n  = 1'b0;
        rst_n   = 1'b0;
        cur_tag = "R8";
        #1 chk(ser_out, 1'b0, "R8");
        for (int i = 0; i < 2; i++) drive(1'b0, 1'b0, 1'b1, 8'hFF, "R8");

        // R2: second release, loads keep requesting
        @(negedge clk);
        #1;
        rst_n   = 1'b1;
        cur_tag = "R2";
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 1'b1, 8'hFF, "R2");
        drive(1'b0, 1'b0, 1'b0, 8'h00, "R3");
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule